// File: doc/BRIEF.md
# Operand Decoder and Extension-Word Fetcher

This block takes one 16-bit instruction word and splits it into a 5-bit opcode and two operand selectors. It turns each selector into a description that an execution stage can use directly. That description has three parts: a kind (register, memory location, stack pointer, program counter, excess register, literal or absent), an address or register index, and a literal value. When an operand carries an inline extension word, the block reads that word from a synchronous memory port at the current program counter and advances the counter. It also applies the stack-pointer side effects of stack operands.

A controller pulses `start` with the instruction word and the current PC and SP. PC already points just past the instruction word. The block resolves the 6-bit selector first and the 5-bit selector second, so extension words are consumed in that order. It then pulses `done` for one cycle. Through `pc_out` and `sp_out` it returns the updated PC and SP, and through `word_cost` the lookup cycle cost. Register contents come from an external register file over a combinational read port. Executing the operation is not part of this block.

Top module: `operand_fetch_unit`

## Requirements
- R1: After reset, `done` and `mem_rd_en` are low, both operand kinds read 6 (absent) and `word_cost` is 0.
- R2: The instruction splits as bits 15:10 = selector a (6 bits), bits 9:5 = selector b (5 bits), bits 4:0 = `opcode`. `special` is high exactly when the opcode is zero, and `special_op` carries bits 9:5.
- R3: Selectors 0x00-0x07 give kind 0 (register) with address = register index. Selectors 0x08-0x0f give kind 1 (memory) with address = contents of register (selector & 7).
- R4: Selectors 0x10-0x17, 0x1a, 0x1e and 0x1f each read one extension word at PC, and PC then increments. The resulting address is register + word, SP + word, or word, all kind 1. For 0x1f the result is kind 5 (literal) with value = word.
- R5: Selector a is resolved before selector b. When both need a word, a's word is read from the lower address.
- R6: Selector 0x18 in a is a pop (address = SP, then SP+1). In b it is a push (SP-1 first, address = new SP). Selector 0x19 addresses SP. Both fields apply their SP effects in order, and SP wraps modulo 2^16.
- R7: Selectors 0x1b, 0x1c and 0x1d give kinds 2 (SP), 3 (PC) and 4 (excess register) respectively.
- R8: Selectors 0x20-0x3f (field a only) give kind 5 with value (selector - 0x21) mod 2^16, so 0x20 yields 0xffff and 0x3f yields 0x001e. No memory is read.
- R9: The write-enable flag (`a_wr`/`b_wr`) is 0 for a literal or absent operand and 1 for every other kind.
- R10: With opcode 0, selector b is not decoded. `b_kind` is 6, `b_wr` is 0, b's address and value are 0, and no word is read for b.
- R11: `word_cost` equals the number of extension words read. `done` is a one-cycle pulse on the (3 + word_cost)-th rising edge, counting the edge that samples `start` as the first.
- R12: Every operand output reads 0 where it does not apply: the address of a literal, and the value of a non-literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `instr` (sampled while idle) |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | PC pointing after the instruction word |
| sp_in | input | 16 | Current stack pointer |
| mem_rd_en | output | 1 | Extension-word read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |
| rf_sel | output | 3 | Register file read index |
| rf_data | input | 16 | Register file read data (combinational) |
| done | output | 1 | Decode complete, one-cycle pulse |
| opcode | output | 5 | Opcode field |
| special | output | 1 | Opcode field is zero |
| special_op | output | 5 | Field b taken as a special opcode |
| a_kind | output | 3 | Kind of operand a |
| a_addr | output | 16 | Address or register index of a |
| a_lit | output | 16 | Literal value of a |
| a_wr | output | 1 | Writes to a take effect |
| b_kind | output | 3 | Kind of operand b |
| b_addr | output | 16 | Address or register index of b |
| b_lit | output | 16 | Literal value of b |
| b_wr | output | 1 | Writes to b take effect |
| word_cost | output | 2 | Extension words read (lookup cycles) |
| pc_out | output | 16 | Updated PC |
| sp_out | output | 16 | Updated SP |

## Verification
The assertions rely on three properties of the inputs. The memory returns data exactly one cycle after the request. The register file read data stays stable while an operand is being resolved. `start` is raised only when the block is idle, once per decode. The stimulus follows these rules. The bench models memory and registers as fixed functions of address and index. It issues each new instruction only after the previous `done`. It covers both stack-pointer wrap directions, together with selector combinations that need zero, one and two extension words.

// File: rtl/opd_pkg.sv
package opd_pkg;

   localparam int unsigned INSTR_W = 16;
   localparam int unsigned OPC_W   = 5;
   localparam int unsigned SELB_W  = 5;
   localparam int unsigned SELA_W  = 6;

   typedef enum logic [2:0] {
      K_REG  = 3'd0,
      K_MEM  = 3'd1,
      K_SP   = 3'd2,
      K_PC   = 3'd3,
      K_EX   = 3'd4,
      K_LIT  = 3'd5,
      K_NONE = 3'd6
   } opd_kind_e;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_ARES  = 3'd1,
      S_AWAIT = 3'd2,
      S_BRES  = 3'd3,
      S_BWAIT = 3'd4,
      S_DONE  = 3'd5
   } opd_state_e;

endpackage

// File: rtl/opd_resolve.sv
module opd_resolve
   import opd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter bit          PUSH_SIDE = 1'b0
) (
   input  logic [SELA_W-1:0] code,
   input  logic [DATA_W-1:0] sp,
   input  logic [DATA_W-1:0] rf_data,
   input  logic [DATA_W-1:0] word,
   output opd_kind_e         kind,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] lit,
   output logic              needs_word,
   output logic              sp_up,
   output logic              sp_down
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] stk_addr;
   logic              stk_up;
   logic              stk_down;

   generate
      if (PUSH_SIDE) begin : g_push
         assign stk_addr = sp - ONE;
         assign stk_up   = 1'b0;
         assign stk_down = 1'b1;
      end else begin : g_pop
         assign stk_addr = sp;
         assign stk_up   = 1'b1;
         assign stk_down = 1'b0;
      end
   endgenerate

   always_comb begin
      kind       = K_REG;
      addr       = '0;
      lit        = '0;
      needs_word = 1'b0;
      sp_up      = 1'b0;
      sp_down    = 1'b0;
      if (code[5]) begin
         kind = K_LIT;
         lit  = DATA_W'(code[4:0]) - ONE;
      end else begin
         case (code[4:3])
            2'b00: begin
               kind = K_REG;
               addr = DATA_W'(code[2:0]);
            end
            2'b01: begin
               kind = K_MEM;
               addr = rf_data;
            end
            2'b10: begin
               kind       = K_MEM;
               addr       = rf_data + word;
               needs_word = 1'b1;
            end
            default: begin
               case (code[2:0])
                  3'd0: begin
                     kind    = K_MEM;
                     addr    = stk_addr;
                     sp_up   = stk_up;
                     sp_down = stk_down;
                  end
                  3'd1: begin
                     kind = K_MEM;
                     addr = sp;
                  end
                  3'd2: begin
                     kind       = K_MEM;
                     addr       = sp + word;
                     needs_word = 1'b1;
                  end
                  3'd3: kind = K_SP;
                  3'd4: kind = K_PC;
                  3'd5: kind = K_EX;
                  3'd6: begin
                     kind       = K_MEM;
                     addr       = word;
                     needs_word = 1'b1;
                  end
                  default: begin
                     kind       = K_LIT;
                     lit        = word;
                     needs_word = 1'b1;
                  end
               endcase
            end
         endcase
      end
   end

   // R6: a stack access never moves SP both ways at once
   always_comb begin
      p_sp_one_dir_r6: assert (!(sp_up && sp_down));
   end

endmodule

// File: rtl/opd_seq.sv
module opd_seq
   import opd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       a_needs,
   input  logic       b_needs,
   input  logic       skip_b,
   output opd_state_e st
);
   opd_state_e st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         S_IDLE:  if (start) st_nx = S_ARES;
         S_ARES:  st_nx = a_needs ? S_AWAIT : S_BRES;
         S_AWAIT: st_nx = S_BRES;
         S_BRES:  st_nx = (!skip_b && b_needs) ? S_BWAIT : S_DONE;
         S_BWAIT: st_nx = S_DONE;
         S_DONE:  st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= S_IDLE;
      else        st <= st_nx;
   end

   // R11: completion lasts exactly one cycle
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DONE) |=> (st == S_IDLE));

   // R11: a started decode always leaves idle
   p_start_leaves_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && start) |=> (st == S_ARES));

endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
   import opd_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_REGS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [15:0]                   instr,
   input  logic [DATA_W-1:0]             pc_in,
   input  logic [DATA_W-1:0]             sp_in,
   output logic                          mem_rd_en,
   output logic [DATA_W-1:0]             mem_addr,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic [$clog2(NUM_REGS)-1:0]   rf_sel,
   input  logic [DATA_W-1:0]             rf_data,
   output logic                          done,
   output logic [4:0]                    opcode,
   output logic                          special,
   output logic [4:0]                    special_op,
   output logic [2:0]                    a_kind,
   output logic [DATA_W-1:0]             a_addr,
   output logic [DATA_W-1:0]             a_lit,
   output logic                          a_wr,
   output logic [2:0]                    b_kind,
   output logic [DATA_W-1:0]             b_addr,
   output logic [DATA_W-1:0]             b_lit,
   output logic                          b_wr,
   output logic [1:0]                    word_cost,
   output logic [DATA_W-1:0]             pc_out,
   output logic [DATA_W-1:0]             sp_out
);
   localparam int unsigned SEL_W  = $clog2(NUM_REGS);
   localparam int unsigned COST_W = 2;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W < INSTR_W) begin : g_bad_width
         $error("DATA_W must hold a full instruction word");
      end
      if (NUM_REGS != 8) begin : g_bad_regs
         $error("selector encoding covers exactly eight registers");
      end
   endgenerate

   opd_state_e st;

   logic [INSTR_W-1:0] instr_q;
   logic [DATA_W-1:0]  pc_q, sp_q;
   logic [COST_W-1:0]  cost_q;
   opd_kind_e          a_kind_q, b_kind_q;
   logic [DATA_W-1:0]  a_addr_q, a_lit_q, b_addr_q, b_lit_q;
   logic               a_wr_q, b_wr_q;

   logic [SELA_W-1:0]  sel_a, sel_b;
   logic               is_special;

   assign sel_a      = instr_q[15:10];
   assign sel_b      = {1'b0, instr_q[9:5]};
   assign is_special = (instr_q[OPC_W-1:0] == '0);

   opd_kind_e          ra_kind, rb_kind;
   logic [DATA_W-1:0]  ra_addr, ra_lit, rb_addr, rb_lit;
   logic               ra_need, rb_need, ra_up, ra_dn, rb_up, rb_dn;

   opd_resolve #(.DATA_W(DATA_W), .PUSH_SIDE(1'b0)) u_res_a (
      .code(sel_a), .sp(sp_q), .rf_data(rf_data), .word(mem_rdata),
      .kind(ra_kind), .addr(ra_addr), .lit(ra_lit), .needs_word(ra_need),
      .sp_up(ra_up), .sp_down(ra_dn)
   );

   opd_resolve #(.DATA_W(DATA_W), .PUSH_SIDE(1'b1)) u_res_b (
      .code(sel_b), .sp(sp_q), .rf_data(rf_data), .word(mem_rdata),
      .kind(rb_kind), .addr(rb_addr), .lit(rb_lit), .needs_word(rb_need),
      .sp_up(rb_up), .sp_down(rb_dn)
   );

   opd_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_needs(ra_need), .b_needs(rb_need), .skip_b(is_special),
      .st(st)
   );

   logic b_phase;
   assign b_phase   = (st == S_BRES) || (st == S_BWAIT);
   assign rf_sel    = b_phase ? sel_b[SEL_W-1:0] : sel_a[SEL_W-1:0];
   assign mem_rd_en = ((st == S_ARES) && ra_need) ||
                      ((st == S_BRES) && !is_special && rb_need);
   assign mem_addr  = pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_q  <= '0;
         pc_q     <= '0;
         sp_q     <= '0;
         cost_q   <= '0;
         a_kind_q <= K_NONE;
         a_addr_q <= '0;
         a_lit_q  <= '0;
         a_wr_q   <= 1'b0;
         b_kind_q <= K_NONE;
         b_addr_q <= '0;
         b_lit_q  <= '0;
         b_wr_q   <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               instr_q  <= instr;
               pc_q     <= pc_in;
               sp_q     <= sp_in;
               cost_q   <= '0;
               a_kind_q <= K_NONE;
               a_addr_q <= '0;
               a_lit_q  <= '0;
               a_wr_q   <= 1'b0;
               b_kind_q <= K_NONE;
               b_addr_q <= '0;
               b_lit_q  <= '0;
               b_wr_q   <= 1'b0;
            end
            S_ARES: begin
               if (ra_need) begin
                  pc_q   <= pc_q + ONE;
                  cost_q <= cost_q + 1'b1;
               end else begin
                  a_kind_q <= ra_kind;
                  a_addr_q <= ra_addr;
                  a_lit_q  <= ra_lit;
                  a_wr_q   <= (ra_kind != K_LIT);
                  if (ra_up)      sp_q <= sp_q + ONE;
                  else if (ra_dn) sp_q <= sp_q - ONE;
               end
            end
            S_AWAIT: begin
               a_kind_q <= ra_kind;
               a_addr_q <= ra_addr;
               a_lit_q  <= ra_lit;
               a_wr_q   <= (ra_kind != K_LIT);
            end
            S_BRES: if (!is_special) begin
               if (rb_need) begin
                  pc_q   <= pc_q + ONE;
                  cost_q <= cost_q + 1'b1;
               end else begin
                  b_kind_q <= rb_kind;
                  b_addr_q <= rb_addr;
                  b_lit_q  <= rb_lit;
                  b_wr_q   <= (rb_kind != K_LIT);
                  if (rb_up)      sp_q <= sp_q + ONE;
                  else if (rb_dn) sp_q <= sp_q - ONE;
               end
            end
            S_BWAIT: begin
               b_kind_q <= rb_kind;
               b_addr_q <= rb_addr;
               b_lit_q  <= rb_lit;
               b_wr_q   <= (rb_kind != K_LIT);
            end
            default: ;
         endcase
      end
   end

   assign done       = (st == S_DONE);
   assign opcode     = instr_q[OPC_W-1:0];
   assign special    = is_special;
   assign special_op = instr_q[9:5];
   assign a_kind     = a_kind_q;
   assign a_addr     = a_addr_q;
   assign a_lit      = a_lit_q;
   assign a_wr       = a_wr_q;
   assign b_kind     = b_kind_q;
   assign b_addr     = b_addr_q;
   assign b_lit      = b_lit_q;
   assign b_wr       = b_wr_q;
   assign word_cost  = cost_q;
   assign pc_out     = pc_q;
   assign sp_out     = sp_q;

   // R4: every extension-word read advances PC by one
   p_fetch_moves_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (pc_out == DATA_W'($past(pc_out) + ONE)));

   // R10: no word is read for b when the opcode is special
   p_special_no_b_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (b_phase && special) |-> !mem_rd_en);

   // R1: the memory port is quiet while idle
   p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !mem_rd_en);

   // R6: SP moves at most one step per cycle during a decode
   p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE) |=> ((sp_out == $past(sp_out)) ||
                          (sp_out == DATA_W'($past(sp_out) + ONE)) ||
                          (sp_out == DATA_W'($past(sp_out) - ONE))));

   // R9: a completed literal operand is never writable
   p_lit_not_writable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && a_kind == 3'd5) |-> !a_wr);

endmodule

// File: tb/tb_operand_fetch_unit.sv
module tb_operand_fetch_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0, pc_in = '0, sp_in = '0;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic [2:0]  rf_sel;
   logic [15:0] rf_data;
   logic        done, special, a_wr, b_wr;
   logic [4:0]  opcode, special_op;
   logic [2:0]  a_kind, b_kind;
   logic [15:0] a_addr, a_lit, b_addr, b_lit, pc_out, sp_out;
   logic [1:0]  word_cost;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] memf(input logic [15:0] a);
      return 16'(a * 16'h0103 + 16'h002a);
   endfunction
   function automatic logic [15:0] regv(input logic [2:0] i);
      return 16'(16'h1100 + 16'(i) * 16'h0111);
   endfunction

   assign rf_data = regv(rf_sel);
   always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

   operand_fetch_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .pc_in(pc_in), .sp_in(sp_in), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .rf_sel(rf_sel), .rf_data(rf_data), .done(done),
      .opcode(opcode), .special(special), .special_op(special_op),
      .a_kind(a_kind), .a_addr(a_addr), .a_lit(a_lit), .a_wr(a_wr),
      .b_kind(b_kind), .b_addr(b_addr), .b_lit(b_lit), .b_wr(b_wr),
      .word_cost(word_cost), .pc_out(pc_out), .sp_out(sp_out)
   );

   typedef struct {
      logic [4:0]  op;
      logic        spc;
      logic [4:0]  sop;
      logic [2:0]  ak, bk;
      logic [15:0] aa, al, ba, bl;
      logic        aw, bw;
      logic [1:0]  cost;
      logic [15:0] pc, sp;
      int          due;
      string       tag;
   } exp_t;

   exp_t sb[$];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference resolution of one selector, written from the requirements
   task automatic model(input logic [5:0] code, input bit is_b,
                        inout logic [15:0] pc, inout logic [15:0] sp, inout int nw,
                        output logic [2:0] k, output logic [15:0] ad,
                        output logic [15:0] li, output logic wr);
      logic [15:0] w;
      ad = '0; li = '0;
      if (code >= 6'h20) begin
         k = 3'd5; li = 16'(int'(code) - 33);
      end else if (code < 6'h08) begin
         k = 3'd0; ad = 16'(code);
      end else if (code < 6'h10) begin
         k = 3'd1; ad = regv(code[2:0]);
      end else if (code < 6'h18) begin
         w = memf(pc); pc++; nw++;
         k = 3'd1; ad = 16'(regv(code[2:0]) + w);
      end else begin
         case (code)
            6'h18: begin
               k = 3'd1;
               if (is_b) begin sp--; ad = sp; end
               else begin ad = sp; sp++; end
            end
            6'h19: begin k = 3'd1; ad = sp; end
            6'h1a: begin w = memf(pc); pc++; nw++; k = 3'd1; ad = 16'(sp + w); end
            6'h1b: k = 3'd2;
            6'h1c: k = 3'd3;
            6'h1d: k = 3'd4;
            6'h1e: begin w = memf(pc); pc++; nw++; k = 3'd1; ad = w; end
            default: begin w = memf(pc); pc++; nw++; k = 3'd5; li = w; end
         endcase
      end
      wr = (k != 3'd5);
   endtask

   // driver: compute expectation, push it, then issue the instruction
   task automatic drive(input string tag, input logic [5:0] sa, input logic [4:0] sb_f,
                        input logic [4:0] op, input logic [15:0] pc, input logic [15:0] sp);
      exp_t e;
      int nw = 0;
      logic [15:0] p = pc, s = sp;
      e.op = op; e.spc = (op == 5'd0); e.sop = sb_f; e.tag = tag;
      model(sa, 1'b0, p, s, nw, e.ak, e.aa, e.al, e.aw);
      if (op == 5'd0) begin
         e.bk = 3'd6; e.ba = '0; e.bl = '0; e.bw = 1'b0;
      end else begin
         model({1'b0, sb_f}, 1'b1, p, s, nw, e.bk, e.ba, e.bl, e.bw);
      end
      e.cost = 2'(nw); e.pc = p; e.sp = s;
      @(negedge clk);
      instr = {sa, sb_f, op}; pc_in = pc; sp_in = sp; start = 1'b1;
      e.due = cyc + 1 + 2 + nw;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: pop and compare on each completion
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk("R11", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R11", {e.tag, " done timing"}, cyc, e.due);
            chk("R11", {e.tag, " word_cost"}, word_cost, e.cost);
            chk("R2",  {e.tag, " opcode"}, opcode, e.op);
            chk("R2",  {e.tag, " special"}, special, e.spc);
            chk("R2",  {e.tag, " special_op"}, special_op, e.sop);
            chk("R3",  {e.tag, " a_kind"}, a_kind, e.ak);
            chk("R4",  {e.tag, " a_addr"}, a_addr, e.aa);
            chk("R12", {e.tag, " a_lit"}, a_lit, e.al);
            chk("R9",  {e.tag, " a_wr"}, a_wr, e.aw);
            chk("R7",  {e.tag, " b_kind"}, b_kind, e.bk);
            chk("R5",  {e.tag, " b_addr"}, b_addr, e.ba);
            chk("R12", {e.tag, " b_lit"}, b_lit, e.bl);
            chk("R9",  {e.tag, " b_wr"}, b_wr, e.bw);
            chk("R4",  {e.tag, " pc_out"}, pc_out, e.pc);
            chk("R6",  {e.tag, " sp_out"}, sp_out, e.sp);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "done after reset", done, 1'b0);
      chk("R1", "mem_rd_en after reset", mem_rd_en, 1'b0);
      chk("R1", "a_kind after reset", a_kind, 3'd6);
      chk("R1", "b_kind after reset", b_kind, 3'd6);
      chk("R1", "word_cost after reset", word_cost, 2'd0);

      drive("R3_regs",     6'h0b, 5'h03, 5'h01, 16'h0040, 16'h8000);
      drive("R5_order",    6'h12, 5'h1e, 5'h02, 16'h0100, 16'h8000);
      drive("R6_poppush",  6'h18, 5'h18, 5'h01, 16'h0200, 16'h7ff0);
      drive("R6_pick",     6'h1a, 5'h19, 5'h03, 16'h0300, 16'h1234);
      drive("R7_litsp",    6'h1f, 5'h1b, 5'h01, 16'h0400, 16'h4000);
      drive("R8_minus1",   6'h20, 5'h1c, 5'h12, 16'h0500, 16'h4000);
      drive("R8_top",      6'h3f, 5'h1d, 5'h0c, 16'h0600, 16'h4000);
      drive("R8_zero",     6'h21, 5'h07, 5'h1f, 16'h0700, 16'h4000);
      drive("R10_special", 6'h10, 5'h01, 5'h00, 16'h0800, 16'h2000);
      drive("R10_spec_lit",6'h1f, 5'h1a, 5'h00, 16'h0900, 16'h2000);
      drive("R6_wrap_dn",  6'h05, 5'h18, 5'h01, 16'h0a00, 16'h0000);
      drive("R6_wrap_up",  6'h18, 5'h1a, 5'h01, 16'hfffe, 16'hffff);
      drive("R4_idx_lit",  6'h17, 5'h1e, 5'h01, 16'hffff, 16'h3000);

      repeat (3) @(negedge clk);
      chk("R11", "scoreboard drained", sb.size(), 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R11 watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule